// File: doc/BRIEF.md
# Manual Reset Exception Sequencer

This block turns a manual reset request into the CPU-side restart sequence. A request comes from one of two sources. The first is an active-low pin. It counts only if the pin was held low for a minimum number of clock cycles, and it takes effect when the pin returns high. The second is a watchdog overflow strobe that needs no width check. When a request is accepted, the block waits until the CPU has the bus. It then reads two 32-bit vectors through a valid/ready read port: the start address from byte offset 0x08 and the initial stack pointer from offset 0x0C. Both offsets are fixed and do not depend on the vector base.

After the second read completes, the block commits both values to the program counter and stack pointer outputs in one cycle. In that same cycle it also clears the vector base, sets the status-register fields to their restart values, and raises a one-cycle clear strobe for the interrupt controller's bank-number bit. A one-cycle `done` pulse in that cycle releases program execution. While the block is idle, the core may write the vector base and status fields through a write port. Peripheral and floating-point state are not part of the block.

State machine: `ST_IDLE` goes to `ST_WAIT_BUS` on an accepted request. `ST_WAIT_BUS` goes to `ST_FETCH_PC` once the bus is free. `ST_FETCH_PC` goes to `ST_FETCH_SP` on a read handshake. `ST_FETCH_SP` goes to `ST_LOAD` on a read handshake. `ST_LOAD` goes back to `ST_IDLE` unconditionally.

Top module: `mrst_seq`

## Requirements
- R1: After power-on reset the state is as follows. `pc_out`, `sp_out` and `vbr_out` are 0. `sr_imask` is 4'b1111. `sr_bo`, `sr_cs`, `done`, `bank_clr`, `rd_req` and `busy` are 0.
- R2: The pin must be sampled low on at least 20 consecutive rising clock edges. The request is then accepted on the first edge that samples it high again, so `busy` is set in the cycle after that edge. No read is issued while the pin is low.
- R3: A low pin pulse sampled on fewer than 20 edges starts no sequence: `busy` stays 0 and no read is issued.
- R4: A one-cycle `wdt_ovf` pulse in `ST_IDLE` starts the same sequence without any width check.
- R5: The bus is free only when `bus_rel`, `dma_burst` and `cyc_busy` are all 0. No read request starts while the bus is not free, and the sequence stays in `ST_WAIT_BUS` until it is.
- R6: The first read uses address 0x08 and the second uses address 0x0C. `rd_req` and `rd_addr` are held until `rd_ready` is seen.
- R7: On completion, the `done` and `bank_clr` outputs are high for exactly one cycle. In that cycle `pc_out` holds the data from the 0x08 read and `sp_out` holds the data from the 0x0C read. `vbr_out` is 0, `sr_imask` is 4'b1111, and `sr_bo` and `sr_cs` are 0.
- R8: Requests that arrive while `busy` is 1 are dropped: each accepted request produces exactly one `done`.
- R9: A core write (`core_we`) updates `vbr_out`, `sr_imask`, `sr_bo` and `sr_cs` on the next edge when `busy` is 0. When `busy` is 1 the write has no effect.
- R10: `pc_out` and `sp_out` change only in a cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| mres_n | input | 1 | Manual reset pin, active low, synchronous to clk |
| wdt_ovf | input | 1 | Watchdog overflow configured for manual reset, one-cycle pulse |
| bus_rel | input | 1 | Bus is granted to another master |
| dma_burst | input | 1 | DMA burst transfer in progress |
| cyc_busy | input | 1 | CPU bus cycle still in flight |
| rd_req | output | 1 | Vector read request (valid) |
| rd_addr | output | 32 | Vector read byte address |
| rd_ready | input | 1 | Read data returned this cycle |
| rd_data | input | 32 | Read data |
| core_we | input | 1 | Core control-register write enable |
| core_vbr | input | 32 | Core write value for vector base |
| core_imask | input | 4 | Core write value for interrupt mask |
| core_bo | input | 1 | Core write value for BO status bit |
| core_cs | input | 1 | Core write value for CS status bit |
| pc_out | output | 32 | Program counter |
| sp_out | output | 32 | Stack pointer |
| vbr_out | output | 32 | Vector base |
| sr_imask | output | 4 | Status-register interrupt mask |
| sr_bo | output | 1 | Status-register BO bit |
| sr_cs | output | 1 | Status-register CS bit |
| bank_clr | output | 1 | Clear strobe for interrupt bank-number bit |
| done | output | 1 | Execution release pulse |
| busy | output | 1 | Sequence in progress |

## Verification
If the state register is stuck or skips a state, the effect shows on `rd_req` and `rd_addr` within a cycle of the bus becoming free. A missing or doubled read appears there, and a sequence that never ends leaves `busy` high with no `done`. If the pin counter is wrong, the threshold moves: a 19-cycle pulse starts a sequence, or a 20-cycle pulse fails to start one, and `busy` shows this one cycle after the pin rises. If a fetched vector lands in the wrong capture register, `pc_out` and `sp_out` show swapped or stale values in the `done` cycle.

// File: rtl/mrst_pkg.sv
package mrst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_BUS,
        ST_FETCH_PC,
        ST_FETCH_SP,
        ST_LOAD
    } mrst_state_e;

    localparam logic [3:0] IMASK_RESTART = 4'b1111;
endpackage

// File: rtl/mrst_pin_qual.sv
module mrst_pin_qual #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mres_n,
    output logic pin_trig
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt;
    logic          pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pin_q   <= 1'b1;
        end else begin
            pin_q <= mres_n;
            if (mres_n) begin
                low_cnt <= '0;
            end else if (low_cnt != CNT_MAX) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // accepted only on the low-to-high transition after a long enough low
    assign pin_trig = mres_n && !pin_q && (low_cnt == CNT_MAX);

    // R2
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_trig |=> !pin_trig);
endmodule

// File: rtl/mrst_ctrl_fsm.sv
module mrst_ctrl_fsm
    import mrst_pkg::*;
#(
    parameter int              ADDR_W = 32,
    parameter int              DATA_W = 32,
    parameter logic [ADDR_W-1:0] PC_OFS = 'h8,
    parameter logic [ADDR_W-1:0] SP_OFS = 'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_trig,
    input  logic              wdt_ovf,
    input  logic              bus_free,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] pc_fetch,
    output logic [DATA_W-1:0] sp_fetch,
    output logic              load,
    output logic              busy
);
    mrst_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (pin_trig || wdt_ovf) state_nx = ST_WAIT_BUS;
            ST_WAIT_BUS: if (bus_free)            state_nx = ST_FETCH_PC;
            ST_FETCH_PC: if (rd_ready)            state_nx = ST_FETCH_SP;
            ST_FETCH_SP: if (rd_ready)            state_nx = ST_LOAD;
            ST_LOAD:                              state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_fetch <= '0;
            sp_fetch <= '0;
        end else begin
            if (state == ST_FETCH_PC && rd_ready) pc_fetch <= rd_data;
            if (state == ST_FETCH_SP && rd_ready) sp_fetch <= rd_data;
        end
    end

    always_comb begin
        rd_req  = 1'b0;
        rd_addr = '0;
        load    = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_WAIT_BUS: ;
            ST_FETCH_PC: begin rd_req = 1'b1; rd_addr = PC_OFS; end
            ST_FETCH_SP: begin rd_req = 1'b1; rd_addr = SP_OFS; end
            ST_LOAD:     load = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

    // R5
    no_rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req && !bus_free |=> !rd_req);
endmodule

// File: rtl/mrst_cpu_regs.sv
module mrst_cpu_regs
    import mrst_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [DATA_W-1:0] pc_new,
    input  logic [DATA_W-1:0] sp_new,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_vbr,
    input  logic [3:0]        core_imask,
    input  logic              core_bo,
    input  logic              core_cs,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] sp_out,
    output logic [DATA_W-1:0] vbr_out,
    output logic [3:0]        sr_imask,
    output logic              sr_bo,
    output logic              sr_cs,
    output logic              bank_clr,
    output logic              done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_out   <= '0;
            sp_out   <= '0;
            vbr_out  <= '0;
            sr_imask <= IMASK_RESTART;
            sr_bo    <= 1'b0;
            sr_cs    <= 1'b0;
            bank_clr <= 1'b0;
            done     <= 1'b0;
        end else begin
            bank_clr <= load;
            done     <= load;
            if (load) begin
                pc_out   <= pc_new;
                sp_out   <= sp_new;
                vbr_out  <= '0;
                sr_imask <= IMASK_RESTART;
                sr_bo    <= 1'b0;
                sr_cs    <= 1'b0;
            end else if (core_we && !busy) begin
                vbr_out  <= core_vbr;
                sr_imask <= core_imask;
                sr_bo    <= core_bo;
                sr_cs    <= core_cs;
            end
        end
    end

    // R10
    pc_sp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pc_out) && $stable(sp_out));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !bank_clr);

    // R7
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> vbr_out == '0 && sr_imask == IMASK_RESTART && !sr_bo && !sr_cs);

    // R9
    busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_we && busy |=> vbr_out == '0 || $stable(vbr_out));
endmodule

// File: rtl/mrst_seq.sv
module mrst_seq #(
    parameter int MIN_LOW = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mres_n,
    input  logic        wdt_ovf,
    input  logic        bus_rel,
    input  logic        dma_burst,
    input  logic        cyc_busy,
    output logic        rd_req,
    output logic [31:0] rd_addr,
    input  logic        rd_ready,
    input  logic [31:0] rd_data,
    input  logic        core_we,
    input  logic [31:0] core_vbr,
    input  logic [3:0]  core_imask,
    input  logic        core_bo,
    input  logic        core_cs,
    output logic [31:0] pc_out,
    output logic [31:0] sp_out,
    output logic [31:0] vbr_out,
    output logic [3:0]  sr_imask,
    output logic        sr_bo,
    output logic        sr_cs,
    output logic        bank_clr,
    output logic        done,
    output logic        busy
);
    localparam int W = 32;

    logic          pin_trig;
    logic          bus_free;
    logic          load;
    logic [W-1:0]  pc_fetch;
    logic [W-1:0]  sp_fetch;

    assign bus_free = !bus_rel && !dma_burst && !cyc_busy;

    mrst_pin_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .mres_n   (mres_n),
        .pin_trig (pin_trig)
    );

    mrst_ctrl_fsm #(.ADDR_W(W), .DATA_W(W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_trig (pin_trig),
        .wdt_ovf  (wdt_ovf),
        .bus_free (bus_free),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .pc_fetch (pc_fetch),
        .sp_fetch (sp_fetch),
        .load     (load),
        .busy     (busy)
    );

    mrst_cpu_regs #(.DATA_W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .busy       (busy),
        .pc_new     (pc_fetch),
        .sp_new     (sp_fetch),
        .core_we    (core_we),
        .core_vbr   (core_vbr),
        .core_imask (core_imask),
        .core_bo    (core_bo),
        .core_cs    (core_cs),
        .pc_out     (pc_out),
        .sp_out     (sp_out),
        .vbr_out    (vbr_out),
        .sr_imask   (sr_imask),
        .sr_bo      (sr_bo),
        .sr_cs      (sr_cs),
        .bank_clr   (bank_clr),
        .done       (done)
    );
endmodule

// File: tb/test_mrst_seq.sv
module test_mrst_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, mres_n, wdt_ovf, bus_rel, dma_burst, cyc_busy;
    logic        rd_req, rd_ready;
    logic [31:0] rd_addr, rd_data;
    logic        core_we, core_bo, core_cs;
    logic [31:0] core_vbr;
    logic [3:0]  core_imask;
    logic [31:0] pc_out, sp_out, vbr_out;
    logic [3:0]  sr_imask;
    logic        sr_bo, sr_cs, bank_clr, done, busy;

    logic        mem_en;
    logic [31:0] pc_vec, sp_vec;

    assign rd_ready = rd_req && mem_en;
    assign rd_data  = (rd_addr == 32'h8) ? pc_vec :
                      (rd_addr == 32'hC) ? sp_vec : 32'hDEAD_BEEF;

    mrst_seq i_mrst_seq (
        .clk(clk), .rst_n(rst_n), .mres_n(mres_n), .wdt_ovf(wdt_ovf),
        .bus_rel(bus_rel), .dma_burst(dma_burst), .cyc_busy(cyc_busy),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .core_we(core_we), .core_vbr(core_vbr), .core_imask(core_imask),
        .core_bo(core_bo), .core_cs(core_cs),
        .pc_out(pc_out), .sp_out(sp_out), .vbr_out(vbr_out), .sr_imask(sr_imask),
        .sr_bo(sr_bo), .sr_cs(sr_cs), .bank_clr(bank_clr), .done(done), .busy(busy)
    );

    typedef struct { logic [31:0] pc; logic [31:0] sp; } res_t;

    int          checks = 0;
    int          fails  = 0;
    int          done_cnt = 0;
    bit          req_seen = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] addr_q[$];
    res_t        res_q[$];
    logic [31:0] exp_a;
    res_t        exp_r;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_expect(input logic [31:0] pc, input logic [31:0] sp);
        pc_vec = pc;
        sp_vec = sp;
        addr_q.push_back(32'h8);
        addr_q.push_back(32'hC);
        res_q.push_back('{pc: pc, sp: sp});
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req) req_seen = 1'b1;
            if (rd_req && rd_ready) begin
                if (addr_q.size() == 0) chk(1'b0, "R6 unexpected read", rd_addr, 32'h0);
                else begin
                    exp_a = addr_q.pop_front();
                    chk(rd_addr == exp_a, "R6 read address", rd_addr, exp_a);
                end
            end
            if (done) begin
                done_cnt++;
                if (res_q.size() == 0) chk(1'b0, "R8 extra done", 32'(done_cnt), 32'(done_cnt - 1));
                else begin
                    exp_r = res_q.pop_front();
                    chk(pc_out == exp_r.pc, "R7 pc", pc_out, exp_r.pc);
                    chk(sp_out == exp_r.sp, "R7 sp", sp_out, exp_r.sp);
                    chk(vbr_out == 32'h0, "R7 vbr", vbr_out, 32'h0);
                    chk({sr_imask, sr_bo, sr_cs} == 6'b111100, "R7 sr",
                        32'({sr_imask, sr_bo, sr_cs}), 32'h3C);
                    chk(bank_clr, "R7 bank_clr", 32'(bank_clr), 32'h1);
                end
            end
        end
    end

    task automatic pin_pulse(input int n);
        @(negedge clk) mres_n = 1'b0;
        repeat (n) @(negedge clk);
        mres_n = 1'b1;
    endtask

    task automatic core_write(input logic [31:0] v, input logic [3:0] m, input logic bo, input logic cs);
        @(negedge clk);
        core_we = 1'b1; core_vbr = v; core_imask = m; core_bo = bo; core_cs = cs;
        @(negedge clk);
        core_we = 1'b0;
    endtask

    task automatic wait_done(input int k);
        for (int i = 0; i < 300; i++) begin
            if (done_cnt >= k) break;
            @(negedge clk);
        end
        chk(done_cnt >= k, "R7 completion", 32'(done_cnt), 32'(k));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mres_n = 1'b1; wdt_ovf = 1'b0; bus_rel = 1'b0;
        dma_burst = 1'b0; cyc_busy = 1'b0; mem_en = 1'b1;
        core_we = 1'b0; core_vbr = '0; core_imask = '0; core_bo = 1'b0; core_cs = 1'b0;
        pc_vec = '0; sp_vec = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pc_out == 0 && sp_out == 0 && vbr_out == 0, "R1 pc/sp/vbr", pc_out | sp_out | vbr_out, 32'h0);
        chk({sr_imask, sr_bo, sr_cs} == 6'b111100, "R1 sr", 32'({sr_imask, sr_bo, sr_cs}), 32'h3C);
        chk(!done && !bank_clr && !rd_req && !busy, "R1 strobes",
            32'({done, bank_clr, rd_req, busy}), 32'h0);

        // R9 core write accepted while idle
        core_write(32'h1234_5600, 4'h3, 1'b1, 1'b1);
        chk(vbr_out == 32'h1234_5600, "R9 idle write vbr", vbr_out, 32'h1234_5600);
        chk({sr_imask, sr_bo, sr_cs} == 6'b001111, "R9 idle write sr",
            32'({sr_imask, sr_bo, sr_cs}), 32'h0F);

        // R3 short pulse
        req_seen = 1'b0;
        pin_pulse(19);
        repeat (10) @(negedge clk);
        chk(!req_seen && !busy, "R3 short pulse ignored", 32'({req_seen, busy}), 32'h0);
        chk(done_cnt == 0, "R3 no done", 32'(done_cnt), 32'h0);
        chk(vbr_out == 32'h1234_5600, "R3 vbr untouched", vbr_out, 32'h1234_5600);

        // R2 qualifying pulse, start on rising edge
        push_expect(32'h0000_1000, 32'hFFF8_0000);
        req_seen = 1'b0;
        @(negedge clk) mres_n = 1'b0;
        repeat (19) @(negedge clk);
        chk(!busy && !req_seen, "R2 nothing while low", 32'({busy, req_seen}), 32'h0);
        @(negedge clk) mres_n = 1'b1;
        @(negedge clk);
        chk(busy, "R2 busy after rise", 32'(busy), 32'h1);
        wait_done(1);

        // R4 watchdog trigger with bus released (R5), R8, R9 busy write
        core_write(32'h0BAD_0000, 4'h5, 1'b1, 1'b0);
        push_expect(32'h0000_2468, 32'h8000_0100);
        bus_rel = 1'b1;
        req_seen = 1'b0;
        @(negedge clk) wdt_ovf = 1'b1;
        @(negedge clk) wdt_ovf = 1'b0;
        chk(busy, "R4 watchdog starts", 32'(busy), 32'h1);
        repeat (8) @(negedge clk);
        chk(!req_seen, "R5 held while bus released", 32'(req_seen), 32'h0);
        chk(pc_out == 32'h0000_1000, "R10 pc held mid-sequence", pc_out, 32'h0000_1000);
        core_write(32'hAAAA_0000, 4'h0, 1'b0, 1'b0);
        chk(vbr_out == 32'h0BAD_0000, "R9 busy write ignored", vbr_out, 32'h0BAD_0000);
        @(negedge clk) wdt_ovf = 1'b1;
        @(negedge clk) wdt_ovf = 1'b0;
        mem_en = 1'b0;
        bus_rel = 1'b0;
        repeat (5) @(negedge clk);
        chk(rd_req && rd_addr == 32'h8, "R6 request held", rd_addr, 32'h8);
        mem_en = 1'b1;
        wait_done(2);
        repeat (20) @(negedge clk);
        chk(done_cnt == 2, "R8 one done per request", 32'(done_cnt), 32'h2);
        chk(!busy, "R8 idle after", 32'(busy), 32'h0);

        // R5 DMA burst and in-flight cycle hold-off
        push_expect(32'h0000_3000, 32'h0000_7FF0);
        dma_burst = 1'b1;
        req_seen = 1'b0;
        pin_pulse(25);
        repeat (8) @(negedge clk);
        chk(!req_seen && busy, "R5 held during DMA burst", 32'({req_seen, busy}), 32'h1);
        cyc_busy = 1'b1;
        dma_burst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!req_seen, "R5 held during bus cycle", 32'(req_seen), 32'h0);
        cyc_busy = 1'b0;
        wait_done(3);
        repeat (5) @(negedge clk);

        chk(addr_q.size() == 0 && res_q.size() == 0, "R6 scoreboard drained",
            32'(addr_q.size() + res_q.size()), 32'h0);
        chk(done_cnt == 3, "R8 total done", 32'(done_cnt), 32'h3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule